// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is an 8-bit timer that counts down. A 7-bit prescaler sits in front of it, and the prescaler's division ratio is picked as a power of two. A small register port gives access to three locations: the control/status register, the prescaler and the count. Each time the count decrements to zero, the timer raises a zero flag. When interrupts are enabled, that flag also drives an interrupt request. Software clears the flag by reading the control register.

One timer pin serves three roles. With the pin set as an output, the block latches a programmed level onto it at every timeout. With the pin set as an input, the block can use it in two ways. In event mode it counts rising edges on the pin. In gated mode the pin enables the internal machine-cycle ticks while it is high. The pin input passes through a two-flop synchronizer. The rules for simultaneous events are precise: a software write to the count or prescaler wins over a decrement in the same cycle, and a control access in the same cycle as a timeout keeps the flag from being set.

Top module: `pdt_timer`

## Requirements
- R1: Reset gives count 0xFF, prescaler 0x7F, control 0x00, pin_out 1, pin_oe 0 and irq 0.
- R2: Register addresses are 0 for control, 1 for prescaler and 2 for count. Address 3 reads 0x00. The prescaler reads with bit 7 equal to 0. Writes load the addressed register.
- R3: Control bits 2..0 give a tap n. While running, the count decrements once per 2^n prescaler ticks, and the first decrement comes on the 2^n-th tick after the prescaler was all ones.
- R4: Control layout: bit 7 zero flag, bit 6 interrupt enable, bit 5 pin direction (1 = output), bit 4 pin level/mode, bit 3 run, bits 2..0 tap.
- R5: While run = 0 no counting occurs and the prescaler is held at 0x7F.
- R6: A decrement from 1 to 0 sets the zero flag. A decrement from 0 wraps to 0xFF.
- R7: Reading control clears the zero flag. Writing 0x00 to the count sets it. A control write loads the flag from bit 7.
- R8: A write to the count or prescaler in the same cycle as a decrement to zero cancels that decrement. The flag is not set and the pin is not updated.
- R9: A control read or write in the same cycle as a timeout leaves the flag unset by that timeout.
- R10: With direction = 1, pin_oe is 1 and each timeout copies the level bit to pin_out. pin_out changes at no other time.
- R11: With direction = 0 and level = 0, each rising edge on pin_in produces exactly one prescaler tick.
- R12: With direction = 0 and level = 1, a tick occurs on each mc_en cycle while the synchronized pin is high. With mc_en low there are no ticks.
- R13: irq is high exactly when the zero flag and interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_en | input | 1 | Machine-cycle clock enable |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears flag at address 0) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on reg_addr |
| pin_in | input | 1 | Timer pin input value |
| pin_out | output | 1 | Timer pin output value |
| pin_oe | output | 1 | Timer pin output enable |
| zero_flag | output | 1 | Zero flag |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, internal ticks and timeouts take effect at the first clock edge after the strobe. A pin edge reaches the prescaler three edges after pin_in changes: two synchronizer flops plus one edge-history flop. Read data is combinational, so each read is sampled before the edge that the read strobe spans. Flag, irq and pin checks are made at the falling edge right after the edge of interest. The tests for simultaneous events place the write or read on exactly the edge where the count would reach zero. Pin-driven tests wait out the full synchronizer delay before reading the count.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  localparam int DATA_W = 8;
  localparam int PRE_W  = 7;
  localparam int TAP_W  = 3;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_PRE  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;

  typedef struct packed {
    logic             zf;
    logic             ie;
    logic             dir_out;
    logic             level;
    logic             run;
    logic [TAP_W-1:0] tap;
  } ctrl_t;
endpackage

// File: rtl/pdt_pin_sync.sv
module pdt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic mc_en,
  input  logic run,
  input  logic dir_out,
  input  logic level,
  output logic tick
);
  logic [STAGES:0] sync_q, sync_d;
  logic            synced, prev, rise;

  always_comb begin
    sync_d = {sync_q[STAGES-1:0], pin_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign synced = sync_q[STAGES-1];
  assign prev   = sync_q[STAGES];
  assign rise   = synced & ~prev;

  always_comb begin
    if (!run)         tick = 1'b0;
    else if (dir_out) tick = mc_en;
    else if (!level)  tick = rise;
    else              tick = mc_en & synced;
  end

  // R11: in event mode a tick needs a fresh rising edge of the synchronized pin
  assert_event_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !dir_out && !level) |-> (sync_q[STAGES-1] && !sync_q[STAGES]));
endmodule

// File: rtl/pdt_prescaler.sv
module pdt_prescaler #(
  parameter int W  = 7,
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  input  logic [TW-1:0] tap,
  output logic [W-1:0]  pre_q,
  output logic          pulse
);
  logic [W-1:0] pre_d;
  logic [W-1:0] mask;

  always_comb begin
    for (int i = 0; i < W; i++) mask[i] = (i < int'(tap));
  end

  assign pulse = tick & ((pre_q & mask) == '0);

  always_comb begin
    if (!run)      pre_d = '1;
    else if (load) pre_d = load_val;
    else if (tick) pre_d = pre_q - 1'b1;
    else           pre_d = pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '1;
    else        pre_q <= pre_d;
  end

  assert_stop_forces_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == {W{1'b1}}));

  assert_tick_steps_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !load) |=> (pre_q == $past(pre_q) - 1'b1));
endmodule

// File: rtl/pdt_counter.sv
module pdt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pulse,
  input  logic         load,
  input  logic         hold,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q,
  output logic         timeout
);
  logic [W-1:0] cnt_d;
  logic         step;

  assign step    = pulse & ~load & ~hold;
  assign timeout = step & (cnt_q == W'(1));

  always_comb begin
    if (load)      cnt_d = load_val;
    else if (step) cnt_d = cnt_q - 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  assert_decrement_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !load && !hold) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
  import pdt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              zero_flag,
  output logic              irq
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ctrl_t             ctrl_q, ctrl_d;
  logic              out_q, out_d;
  logic              wr_ctrl, rd_ctrl, wr_pre, wr_cnt;
  logic              tick, pulse, timeout;
  logic [PRE_W-1:0]  pre_q;
  logic [DATA_W-1:0] cnt_q;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign rd_ctrl = reg_rd && !reg_wr && (reg_addr == A_CTRL);
  assign wr_pre  = reg_wr && (reg_addr == A_PRE);
  assign wr_cnt  = reg_wr && (reg_addr == A_CNT);

  pdt_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_int_n), .pin_in(pin_in), .mc_en(mc_en),
    .run(ctrl_q.run), .dir_out(ctrl_q.dir_out), .level(ctrl_q.level),
    .tick(tick)
  );

  pdt_prescaler #(.W(PRE_W), .TW(TAP_W)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .run(ctrl_q.run), .tick(tick),
    .load(wr_pre), .load_val(reg_wdata[PRE_W-1:0]), .tap(ctrl_q.tap),
    .pre_q(pre_q), .pulse(pulse)
  );

  pdt_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .pulse(pulse), .load(wr_cnt),
    .hold(wr_pre), .load_val(reg_wdata), .cnt_q(cnt_q), .timeout(timeout)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d = ctrl_t'(reg_wdata);
    end else if (rd_ctrl) begin
      ctrl_d.zf = 1'b0;
    end else if (wr_cnt && (reg_wdata == '0)) begin
      ctrl_d.zf = 1'b1;
    end else if (timeout) begin
      ctrl_d.zf = 1'b1;
    end
  end

  always_comb begin
    out_d = out_q;
    if (timeout && ctrl_q.dir_out) out_d = ctrl_q.level;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q <= '0;
      out_q  <= 1'b1;
    end else begin
      ctrl_q <= ctrl_d;
      out_q  <= out_d;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_PRE:   reg_rdata = {{(DATA_W-PRE_W){1'b0}}, pre_q};
      A_CNT:   reg_rdata = cnt_q;
      default: reg_rdata = '0;
    endcase
  end

  assign pin_out   = out_q;
  assign pin_oe    = ctrl_q.dir_out;
  assign zero_flag = ctrl_q.zf;
  assign irq       = ctrl_q.zf & ctrl_q.ie;

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_ctrl |=> !zero_flag);

  assert_access_masks_timeout_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (timeout && wr_ctrl && !reg_wdata[7]) |=> !zero_flag);

  assert_pin_moves_on_timeout_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(pin_out) |-> $past(timeout && pin_oe));
endmodule

// File: tb/pdt_timer_tb.sv
module pdt_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mc_en;
  logic [1:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       pin_in, pin_out, pin_oe, zero_flag, irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .zero_flag(zero_flag), .irq(irq)
  );

  // tap, extra cycles K (ticks = K+1), expected count from 0x80
  localparam logic [26:0] VEC [6] = '{
    {3'd0, 16'd9,   8'h76},
    {3'd1, 16'd9,   8'h7B},
    {3'd2, 16'd14,  8'h7D},
    {3'd3, 16'd31,  8'h7C},
    {3'd4, 16'd47,  8'h7D},
    {3'd7, 16'd255, 8'h7E}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mc_en = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_wdata = '0; pin_in = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(2'd2, rv); check("R1 count", rv, 8'hFF);
    rd(2'd1, rv); check("R1 prescaler", rv, 8'h7F);
    rd(2'd0, rv); check("R1 control", rv, 8'h00);
    check("R1 pin_out", {7'd0, pin_out}, 8'h01);
    check("R1 pin_oe", {7'd0, pin_oe}, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R2 map, prescaler load, event mode with idle pin
    wr(2'd0, 8'h08);
    wr(2'd1, 8'h55); rd(2'd1, rv); check("R2 prescaler 55", rv, 8'h55);
    wr(2'd1, 8'hAA); rd(2'd1, rv); check("R2 prescaler bit7", rv, 8'h2A);
    rd(2'd3, rv); check("R2 addr3", rv, 8'h00);
    rd(2'd0, rv); check("R2 R4 control readback", rv, 8'h08);

    // R3 R5 tap table
    foreach (VEC[i]) begin
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h80);
      wr(2'd0, 8'h28 | {5'd0, VEC[i][26:24]});
      idle(int'(VEC[i][23:8]));
      wr(2'd0, 8'h20);
      rd(2'd2, rv); check($sformatf("R3 tap %0d", VEC[i][26:24]), rv, VEC[i][7:0]);
      rd(2'd1, rv); check("R5 prescaler held", rv, 8'h7F);
    end
    idle(3);
    rd(2'd2, rv); check("R5 stopped count", rv, 8'h7E);

    // R6 R10 R13 timeout in output mode
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h03);
    wr(2'd0, 8'h68);
    idle(2);
    check("R13 irq before", {7'd0, irq}, 8'h00);
    check("R10 pin before", {7'd0, pin_out}, 8'h01);
    idle(1);
    check("R6 R13 irq at zero", {7'd0, irq}, 8'h01);
    check("R10 pin at zero", {7'd0, pin_out}, 8'h00);
    check("R10 pin_oe", {7'd0, pin_oe}, 8'h01);
    rd(2'd0, rv); check("R4 R6 flag read", rv, 8'hE8);
    check("R7 irq after read", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h20);
    rd(2'd2, rv); check("R6 wrap", rv, 8'hFE);
    check("R10 pin held", {7'd0, pin_out}, 8'h00);

    // R7 flag set paths
    wr(2'd2, 8'h00);
    rd(2'd0, rv); check("R7 zero write sets", rv, 8'hA0);
    rd(2'd0, rv); check("R7 read cleared", rv, 8'h20);
    wr(2'd0, 8'hA0);
    rd(2'd0, rv); check("R7 bit7 write sets", rv, 8'hA0);
    wr(2'd0, 8'hE0);
    check("R13 irq set", {7'd0, irq}, 8'h01);
    rd(2'd0, rv);
    check("R13 irq cleared", {7'd0, irq}, 8'h00);

    // R8 count write beats decrement to zero
    wr(2'd0, 8'h20);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h78);
    wr(2'd2, 8'h05);
    check("R8 cnt write irq", {7'd0, irq}, 8'h00);
    check("R8 cnt write pin", {7'd0, pin_out}, 8'h00);
    rd(2'd2, rv); check("R8 cnt write value", rv, 8'h05);
    wr(2'd0, 8'h30);
    // R8 prescaler write beats decrement to zero
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h78);
    wr(2'd1, 8'h00);
    check("R8 pre write irq", {7'd0, irq}, 8'h00);
    check("R8 pre write pin", {7'd0, pin_out}, 8'h00);
    rd(2'd2, rv); check("R8 pre write count", rv, 8'h01);
    check("R10 later timeout pin", {7'd0, pin_out}, 8'h01);
    check("R6 later timeout irq", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h20);

    // R9 control read coincides with timeout
    wr(2'd2, 8'h02);
    wr(2'd0, 8'h68);
    idle(1);
    rd(2'd0, rv); check("R9 read value", rv, 8'h68);
    check("R9 irq after read", {7'd0, irq}, 8'h00);
    check("R10 pin on timeout", {7'd0, pin_out}, 8'h00);
    wr(2'd0, 8'h20);
    rd(2'd0, rv); check("R9 flag after read", rv, 8'h20);
    // R9 control write coincides with timeout
    wr(2'd2, 8'h02);
    wr(2'd0, 8'h78);
    idle(1);
    wr(2'd0, 8'h78);
    check("R9 irq after write", {7'd0, irq}, 8'h00);
    check("R10 pin level 1", {7'd0, pin_out}, 8'h01);
    wr(2'd0, 8'h30);
    rd(2'd0, rv); check("R9 flag after write", rv, 8'h30);

    // R11 event counting
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h10);
    wr(2'd0, 8'h08);
    check("R11 pin_oe input", {7'd0, pin_oe}, 8'h00);
    for (int p = 0; p < 4; p++) begin
      pin_in = 1'b1; idle(3);
      pin_in = 1'b0; idle(3);
    end
    idle(5);
    rd(2'd2, rv); check("R11 four edges", rv, 8'h0C);
    pin_in = 1'b1; idle(8);
    rd(2'd2, rv); check("R11 level high one edge", rv, 8'h0B);
    pin_in = 1'b0; idle(4);

    // R12 gated mode
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h40);
    wr(2'd0, 8'h18);
    pin_in = 1'b1; idle(10);
    pin_in = 1'b0; idle(6);
    rd(2'd2, rv); check("R12 gated ticks", rv, 8'h36);
    mc_en = 1'b0;
    pin_in = 1'b1; idle(5);
    pin_in = 1'b0; idle(4);
    mc_en = 1'b1;
    rd(2'd2, rv); check("R12 mc_en low", rv, 8'h36);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule